// File: doc/BRIEF.md
# Time-Code Tick Generator

This block is a free-running master timer that produces a periodic tick and a wrapping time-code for the serial link channels that take their time reference from it. A programmable 32-bit terminal count sets the period. Each time the internal counter reaches that value, the counter restarts from zero, the six-bit time-code advances by one, and a one-cycle tick strobe is issued.

Each channel has its own 3-bit source-select field. Only channels whose field holds the master-timer code receive a tick from this block. The 8-bit time-code output places two host-programmed flag bits above the six-bit count. The count is also shown in a 32-bit status word for readback. Sending the code over a link and decoding the host bus are handled elsewhere. The block runs on the link clock.

Top module: `tc_tick_gen`

## Requirements
- R1: While reset is held, and until the first terminal-count event after it, `tick_o` and every bit of `chan_tick_o` are 0, the count in `timecode_o[5:0]` is 0, and `status_o` is all zeros.
- R2: With a nonzero terminal count T held constant, consecutive rising edges of `tick_o` are exactly T+1 clock cycles apart.
- R3: `tick_o` is high for exactly one clock cycle per terminal-count event.
- R4: The six-bit count advances by one in the same cycle that `tick_o` is high, stays unchanged in every other cycle, and wraps from 63 to 0.
- R5: `timecode_o[7:6]` equals `flags_i[1:0]` and `timecode_o[5:0]` is the six-bit count.
- R6: Channel n uses the field `src_sel_i[3n+2:3n]`. `chan_tick_o[n]` pulses together with `tick_o` only when the field held the value 3'b001 (master timer) at the event. The values 0 and 2 to 7 give that channel no tick.
- R7: A terminal count of 0 stops the timer: no tick is issued and the count holds its value.
- R8: `status_o[17:12]` carries the six-bit count. All other bits of `status_o` read 0.
- R9: If the terminal count is changed to a value at or below the current counter value, the event occurs at the next clock edge, so `tick_o` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| term_i | input | 32 | Terminal count of the divider; 0 stops the timer |
| flags_i | input | 2 | Control flags placed in time-code bits 7:6 |
| src_sel_i | input | 12 | Four 3-bit per-channel source selects; 3'b001 selects the master timer |
| tick_o | output | 1 | One-cycle master tick strobe |
| chan_tick_o | output | 4 | Per-channel tick, gated by the source select |
| timecode_o | output | 8 | Flags and six-bit count |
| status_o | output | 32 | Readback word with the count in bits 17:12 |

## Verification
The terminal-count event can fall in the same cycle as a change of a channel's source select, or as a change of the terminal count itself. The bench lowers the terminal count below the running counter and expects a tick in the very next cycle. It also switches the count to zero and expects no tick and a frozen code. It changes the select codes between events and judges each channel's tick against the select value that was present at the event edge.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int CODE_W     = 6;
  localparam int FLAG_W     = 2;
  localparam int TC_W       = CODE_W + FLAG_W;
  localparam int SRC_W      = 3;
  localparam int STAT_W     = 32;
  localparam int STAT_LSB   = 12;
  localparam logic [SRC_W-1:0] SRC_MASTER = 3'd1;
endpackage

// File: rtl/tc_divider.sv
module tc_divider #(
  parameter int DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] term_i,
  output logic             event_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en  = (term_i != '0);
    event_o = cnt_en && (cnt_q >= term_i);
    cnt_d   = event_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tc_code_cnt.sv
module tc_code_cnt
  import tc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;

  always_comb code_d = code_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     code_q <= '0;
    else if (adv_i) code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/tc_chan_gate.sv
module tc_chan_gate
  import tc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             event_i,
  input  logic [SRC_W-1:0] sel_i,
  output logic             tick_o
);
  logic tick_d;
  logic tick_q;

  always_comb tick_d = event_i && (sel_i == SRC_MASTER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_d;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/tc_tick_gen.sv
module tc_tick_gen
  import tc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DIV_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DIV_W-1:0]        term_i,
  input  logic [FLAG_W-1:0]       flags_i,
  input  logic [NUM_CH*SRC_W-1:0] src_sel_i,
  output logic                    tick_o,
  output logic [NUM_CH-1:0]       chan_tick_o,
  output logic [TC_W-1:0]         timecode_o,
  output logic [STAT_W-1:0]       status_o
);
  logic              rst_meta_q;
  logic              rst_sync_q;
  logic              tc_event;
  logic              tick_q;
  logic [CODE_W-1:0] code;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  tc_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .term_i  (term_i),
    .event_o (tc_event)
  );

  tc_code_cnt u_code (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .adv_i  (tc_event),
    .code_o (code)
  );

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) tick_q <= 1'b0;
    else             tick_q <= tc_event;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    tc_chan_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_sync_q),
      .event_i (tc_event),
      .sel_i   (src_sel_i[ch*SRC_W +: SRC_W]),
      .tick_o  (chan_tick_o[ch])
    );
  end

  always_comb begin
    tick_o     = tick_q;
    timecode_o = {flags_i, code};
    status_o   = '0;
    status_o[STAT_LSB +: CODE_W] = code;
  end
endmodule

// File: rtl/tc_tick_chk.sv
module tc_tick_chk
  import tc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DIV_W  = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [DIV_W-1:0]        term_i,
  input logic [NUM_CH*SRC_W-1:0] src_sel_i,
  input logic                    tick_o,
  input logic [NUM_CH-1:0]       chan_tick_o,
  input logic [TC_W-1:0]         timecode_o,
  input logic [STAT_W-1:0]       status_o
);
  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  // R4
  code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> timecode_o[CODE_W-1:0] == CODE_W'($past(timecode_o[CODE_W-1:0]) + 1'b1));

  // R4
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |-> $stable(timecode_o[CODE_W-1:0]));

  // R7
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_i == '0) |=> !tick_o);

  // R8
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[STAT_LSB +: CODE_W] == timecode_o[CODE_W-1:0]);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R6
    chan_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_tick_o[ch] |-> tick_o);
    // R6
    chan_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_tick_o[ch] |-> $past(src_sel_i[ch*SRC_W +: SRC_W]) == SRC_MASTER);
  end
endmodule

bind tc_tick_gen tc_tick_chk #(.NUM_CH(NUM_CH), .DIV_W(DIV_W)) u_tick_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .term_i      (term_i),
  .src_sel_i   (src_sel_i),
  .tick_o      (tick_o),
  .chan_tick_o (chan_tick_o),
  .timecode_o  (timecode_o),
  .status_o    (status_o)
);

// File: tb/test_tc_tick_gen.sv
module test_tc_tick_gen;
  logic        clk;
  logic        rst_n;
  logic [31:0] term;
  logic [1:0]  flags;
  logic [11:0] sel;
  logic        tick;
  logic [3:0]  chan;
  logic [7:0]  tc;
  logic [31:0] status;

  int checks = 0;
  int errors = 0;
  int tick_cnt = 0;
  int cyc = 0;

  tc_tick_gen i_tc_tick_gen (
    .clk(clk), .rst_n(rst_n), .term_i(term), .flags_i(flags),
    .src_sel_i(sel), .tick_o(tick), .chan_tick_o(chan),
    .timecode_o(tc), .status_o(status)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // bench tick counter, settled well before the negedge sampling point
  always @(posedge clk) begin
    #2;
    if (!rst_n) tick_cnt = 0;
    else if (tick) tick_cnt = tick_cnt + 1;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(input int max, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < max);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; term = 32'd4; flags = 2'b00; sel = 12'h001;
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R1 tick", int'(tick), 0);
    check(chan == 4'h0, "R1 chan", int'(chan), 0);
    check(tc[5:0] == 6'd0, "R1 code", int'(tc[5:0]), 0);
    check(status == 32'd0, "R1 status", int'(status), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tick == 1'b0 && status == 32'd0, "R1 after release", int'(status), 0);
  endtask

  task automatic t_period();
    int n;
    term = 32'd4;
    wait_tick(100, n);
    wait_tick(100, n);
    check(n == 5, "R2 period T=4", n, 5);
    @(negedge clk);
    check(tick == 1'b0, "R3 one cycle", int'(tick), 0);
    check(tc[5:0] == 6'(tick_cnt), "R4 code", int'(tc[5:0]), tick_cnt % 64);
    term = 32'd9;
    wait_tick(100, n);
    wait_tick(100, n);
    check(n == 10, "R2 period T=9", n, 10);
  endtask

  task automatic t_wrap();
    int n;
    bit seen_wrap = 0;
    logic [5:0] prev;
    term = 32'd1;
    wait_tick(100, n);
    prev = tc[5:0];
    for (int k = 0; k < 70; k++) begin
      wait_tick(10, n);
      if (prev == 6'd63 && tc[5:0] == 6'd0) seen_wrap = 1;
      prev = tc[5:0];
    end
    check(n == 2, "R2 period T=1", n, 2);
    check(seen_wrap, "R4 wrap 63 to 0", int'(seen_wrap), 1);
    check(tc[5:0] == 6'(tick_cnt), "R4 code after wrap", int'(tc[5:0]), tick_cnt % 64);
  endtask

  task automatic t_flags();
    term = 32'd0;
    flags = 2'b10;
    @(negedge clk);
    check(tc[7:6] == 2'b10, "R5 flags 10", int'(tc[7:6]), 2);
    check(tc[5:0] == 6'(tick_cnt), "R5 count field", int'(tc[5:0]), tick_cnt % 64);
    check(status[17:12] == 6'(tick_cnt), "R8 status code", int'(status[17:12]), tick_cnt % 64);
    check((status & ~32'h0003_F000) == 32'd0, "R8 other bits", int'(status), 0);
    flags = 2'b01;
    @(negedge clk);
    check(tc[7:6] == 2'b01, "R5 flags 01", int'(tc[7:6]), 1);
    flags = 2'b00;
  endtask

  task automatic t_select();
    int n;
    sel = {3'd7, 3'd2, 3'd0, 3'd1};
    term = 32'd3;
    wait_tick(100, n);
    check(chan == 4'b0001, "R6 mixed select", int'(chan), 1);
    sel = {3'd1, 3'd1, 3'd1, 3'd1};
    wait_tick(100, n);
    check(chan == 4'b1111, "R6 all master", int'(chan), 15);
    sel = {3'd1, 3'd0, 3'd3, 3'd0};
    wait_tick(100, n);
    check(chan == 4'b1000, "R6 channel 3 only", int'(chan), 8);
    @(negedge clk);
    check(chan == 4'b0000, "R6 channel tick one cycle", int'(chan), 0);
  endtask

  task automatic t_zero();
    int base;
    int n;
    logic [5:0] code0;
    term = 32'd0;
    @(negedge clk);
    @(negedge clk);
    base = tick_cnt;
    code0 = tc[5:0];
    repeat (50) @(negedge clk);
    check(tick_cnt == base, "R7 no ticks", tick_cnt - base, 0);
    check(tc[5:0] == code0, "R7 code holds", int'(tc[5:0]), int'(code0));
    term = 32'd3;
    wait_tick(20, n);
    check(tick == 1'b1, "R7 resume after nonzero", int'(tick), 1);
  endtask

  task automatic t_lower();
    int base;
    term = 32'd1000;
    @(negedge clk);
    base = tick_cnt;
    repeat (20) @(negedge clk);
    check(tick_cnt == base, "R9 no tick before change", tick_cnt - base, 0);
    term = 32'd5;
    @(negedge clk);
    check(tick == 1'b1, "R9 immediate tick", int'(tick), 1);
    check(tc[5:0] == 6'(tick_cnt), "R9 code advanced", int'(tc[5:0]), tick_cnt % 64);
  endtask

  initial begin
    t_reset();
    t_period();
    t_wrap();
    t_flags();
    t_select();
    t_zero();
    t_lower();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule